// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block decides, for each of the two ALU operands of a five-stage in-order pipeline, where the operand value comes from. The value can be the register value carried in the decode-to-execute register, the result held in the execute-to-memory register, or the final value in the memory-to-writeback register. It also decides when an instruction in decode depends on a load that is still in execute. In that case it raises a one-cycle interlock: the fetch address is held, the fetch-to-decode register is held, and a bubble with cleared write enables is sent into execute.

A small datapath is included. It holds a write-first register file that is read by decode and written by the writeback stage. It also holds the two operand multiplexers driven by the control. The ALU, the memories and the branch logic sit outside. The block's interlock outputs are combinational. Once the bubble reaches execute, the memory-read flag the block sees is clear, so the interlock lasts exactly one cycle.

Top module: `bypass_unit`

## Requirements
- R1: For operand A (source `exRs1`), the select is 2'b10 (memory-stage result) whenever `memRegWrite` is 1, `memRd` is nonzero and `memRd` equals the source index. Operand B (source `exRs2`) follows the same rule.
- R2: The select for an operand is 2'b01 (writeback value) only when `wbRegWrite` is 1, `wbRd` is nonzero and equals the source index, and the R1 condition for that operand is false.
- R3: In every other case the select is 2'b00 (register value). A source index of 0 never forwards.
- R4: The two operands are resolved independently of each other.
- R5: `opA`/`opB` equal `exRegVal1`/`exRegVal2`, `memResult` or `wbValue` according to selects 00, 10 and 01 respectively.
- R6: `pcHold`, `ifIdHold` and `bubble` are 1 in the same cycle that `exMemRead` is 1, `exRd` is nonzero and `exRd` equals `idRs1` or `idRs2`. Otherwise they are 0. A matching producer that is not a load does not hold.
- R7: A load whose destination index is 0 never raises the interlock.
- R8: A register is written at the rising clock edge when `wbRegWrite` is 1 and `wbRd` is nonzero. The decode read ports are combinational.
- R9: When writeback writes the same nonzero index that decode reads in that cycle, the read port returns `wbValue` (write-first).
- R10: Index 0 always reads zero and writes to it are ignored. Reset (`rstN` low, active-low) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| idRs1 | input | IDX_W | Decode source 1 index |
| idRs2 | input | IDX_W | Decode source 2 index |
| exRs1 | input | IDX_W | Execute source 1 index |
| exRs2 | input | IDX_W | Execute source 2 index |
| exRd | input | IDX_W | Execute destination index |
| exMemRead | input | 1 | Execute instruction is a load |
| exRegVal1 | input | XLEN | Register value for operand A |
| exRegVal2 | input | XLEN | Register value for operand B |
| memRd | input | IDX_W | Memory-stage destination |
| memRegWrite | input | 1 | Memory-stage writes a register |
| memResult | input | XLEN | Memory-stage ALU result |
| wbRd | input | IDX_W | Writeback destination |
| wbRegWrite | input | 1 | Writeback writes a register |
| wbValue | input | XLEN | Writeback final value |
| idReadData1 | output | XLEN | Decode read port 1 |
| idReadData2 | output | XLEN | Decode read port 2 |
| fwdSelA | output | 2 | Operand A source select |
| fwdSelB | output | 2 | Operand B source select |
| opA | output | XLEN | Operand A value |
| opB | output | XLEN | Operand B value |
| pcHold | output | 1 | Hold fetch address |
| ifIdHold | output | 1 | Hold fetch-to-decode register |
| bubble | output | 1 | Send bubble into execute |

## Verification
The forwarding and interlock logic holds no state. A wrong priority or a wrong match term therefore shows on `fwdSelA`/`fwdSelB`, `opA`/`opB` or the hold outputs in the same cycle as the input pattern that triggers it. The bench sweeps every index pairing of the small configuration to catch this. The only state is in the register file. A wrong write, a lost reset or a missing write-first path shows on the decode read ports one clock after the write, or in the same cycle for the write-first case.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam logic [1:0] SEL_REG = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  typedef struct packed {
    logic [1:0] selA;
    logic [1:0] selB;
  } fwd_ctrl_t;
endpackage

// File: rtl/bypass_control.sv
module bypass_control #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idRs1,
  input  logic [IDX_W-1:0] idRs2,
  input  logic [IDX_W-1:0] exRs1,
  input  logic [IDX_W-1:0] exRs2,
  input  logic [IDX_W-1:0] exRd,
  input  logic             exMemRead,
  input  logic [IDX_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [IDX_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output bypass_pkg::fwd_ctrl_t ctrl,
  output logic             loadUse
);
  import bypass_pkg::*;

  logic [1:0][IDX_W-1:0] srcIdx;
  logic [1:0][1:0]       sel;
  assign srcIdx[0] = exRs1;
  assign srcIdx[1] = exRs2;

  logic memLive, wbLive;
  assign memLive = memRegWrite && (memRd != '0);
  assign wbLive  = wbRegWrite && (wbRd != '0);

  for (genvar k = 0; k < 2; k++) begin : g_operand
    logic memHit, wbHit;
    assign memHit = memLive && (memRd == srcIdx[k]);
    assign wbHit  = wbLive && (wbRd == srcIdx[k]);
    always_comb begin
      if (memHit)     sel[k] = SEL_MEM;
      else if (wbHit) sel[k] = SEL_WB;
      else            sel[k] = SEL_REG;
    end
  end

  assign ctrl.selA = sel[0];
  assign ctrl.selB = sel[1];

  assign loadUse = exMemRead && (exRd != '0) &&
                   ((exRd == idRs1) || (exRd == idRs2));
endmodule

// File: rtl/bypass_datapath.sv
module bypass_datapath #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bypass_pkg::fwd_ctrl_t ctrl,
  input  logic [IDX_W-1:0] idRs1,
  input  logic [IDX_W-1:0] idRs2,
  input  logic [XLEN-1:0]  exRegVal1,
  input  logic [XLEN-1:0]  exRegVal2,
  input  logic [XLEN-1:0]  memResult,
  input  logic [IDX_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic [XLEN-1:0]  wbValue,
  output logic [XLEN-1:0]  idReadData1,
  output logic [XLEN-1:0]  idReadData2,
  output logic [XLEN-1:0]  opA,
  output logic [XLEN-1:0]  opB
);
  import bypass_pkg::*;

  logic [XLEN-1:0] regs [NREGS];

  assign regs[0] = '0;
  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (wbRegWrite && (wbRd == IDX_W'(g)))
        regs[g] <= wbValue;
    end
  end

  function automatic logic [XLEN-1:0] readPort(input logic [IDX_W-1:0] idx,
                                               input logic [XLEN-1:0] stored);
    if (idx == '0)                       return '0;
    if (wbRegWrite && (wbRd == idx))     return wbValue;
    return stored;
  endfunction

  assign idReadData1 = readPort(idRs1, regs[idRs1]);
  assign idReadData2 = readPort(idRs2, regs[idRs2]);

  function automatic logic [XLEN-1:0] pickOperand(input logic [1:0] s,
                                                  input logic [XLEN-1:0] regVal);
    case (s)
      SEL_MEM: return memResult;
      SEL_WB:  return wbValue;
      default: return regVal;
    endcase
  endfunction

  assign opA = pickOperand(ctrl.selA, exRegVal1);
  assign opB = pickOperand(ctrl.selB, exRegVal2);
endmodule

// File: rtl/bypass_unit.sv
module bypass_unit #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] idRs1,
  input  logic [IDX_W-1:0] idRs2,
  input  logic [IDX_W-1:0] exRs1,
  input  logic [IDX_W-1:0] exRs2,
  input  logic [IDX_W-1:0] exRd,
  input  logic             exMemRead,
  input  logic [XLEN-1:0]  exRegVal1,
  input  logic [XLEN-1:0]  exRegVal2,
  input  logic [IDX_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [XLEN-1:0]  memResult,
  input  logic [IDX_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic [XLEN-1:0]  wbValue,
  output logic [XLEN-1:0]  idReadData1,
  output logic [XLEN-1:0]  idReadData2,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic [XLEN-1:0]  opA,
  output logic [XLEN-1:0]  opB,
  output logic             pcHold,
  output logic             ifIdHold,
  output logic             bubble
);
  bypass_pkg::fwd_ctrl_t ctrl;
  logic loadUse;

  bypass_control #(.IDX_W(IDX_W)) u_ctrl (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exMemRead(exMemRead), .memRd(memRd),
    .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .ctrl(ctrl), .loadUse(loadUse)
  );

  bypass_datapath #(.XLEN(XLEN), .NREGS(NREGS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .idRs1(idRs1), .idRs2(idRs2),
    .exRegVal1(exRegVal1), .exRegVal2(exRegVal2), .memResult(memResult),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .wbValue(wbValue),
    .idReadData1(idReadData1), .idReadData2(idReadData2),
    .opA(opA), .opB(opB)
  );

  assign fwdSelA  = ctrl.selA;
  assign fwdSelB  = ctrl.selB;
  assign pcHold   = loadUse;
  assign ifIdHold = loadUse;
  assign bubble   = loadUse;
endmodule

// File: rtl/bypass_unit_chk.sv
module bypass_unit_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] idRs1,
  input logic [IDX_W-1:0] idRs2,
  input logic [IDX_W-1:0] exRs1,
  input logic [IDX_W-1:0] exRs2,
  input logic [IDX_W-1:0] exRd,
  input logic             exMemRead,
  input logic [XLEN-1:0]  exRegVal1,
  input logic [XLEN-1:0]  exRegVal2,
  input logic [IDX_W-1:0] memRd,
  input logic             memRegWrite,
  input logic [XLEN-1:0]  memResult,
  input logic [IDX_W-1:0] wbRd,
  input logic             wbRegWrite,
  input logic [XLEN-1:0]  wbValue,
  input logic [XLEN-1:0]  idReadData1,
  input logic [XLEN-1:0]  idReadData2,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB,
  input logic [XLEN-1:0]  opA,
  input logic [XLEN-1:0]  opB,
  input logic             pcHold,
  input logic             ifIdHold,
  input logic             bubble
);
  a_r1_mem_first: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd != '0 && memRd == exRs1) |-> fwdSelA == 2'b10);

  a_r2_wb_second: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelB == 2'b01) |-> (wbRegWrite && wbRd != '0 && wbRd == exRs2 &&
                            !(memRegWrite && memRd == exRs2)));

  a_r3_zero_src: assert property (@(posedge clk) disable iff (!rstN)
    (exRs1 == '0) |-> fwdSelA == 2'b00);

  a_r5_operand_value: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA == 2'b00) |-> opA == exRegVal1);

  a_r6_hold_together: assert property (@(posedge clk) disable iff (!rstN)
    (pcHold == ifIdHold) && (ifIdHold == bubble));

  a_r7_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> (exMemRead && exRd != '0));

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wbRegWrite && wbRd != '0 && idRs1 == wbRd) |=>
      ($stable(idRs1) && !wbRegWrite) |-> idReadData1 == $past(wbValue));

  a_r9_write_first: assert property (@(posedge clk) disable iff (!rstN)
    (wbRegWrite && wbRd != '0 && wbRd == idRs2) |-> idReadData2 == wbValue);

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    (idRs1 == '0) |-> idReadData1 == '0);
endmodule

bind bypass_unit bypass_unit_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (.*);

// File: tb/bypass_unit_bench.sv
`timescale 1ns/1ps
module bypass_unit_bench;
  localparam int XLEN = 32;
  localparam int NREGS = 8;
  localparam int IDX_W = 3;

  logic clk = 0, rstN = 0;
  logic [IDX_W-1:0] idRs1 = 0, idRs2 = 0, exRs1 = 0, exRs2 = 0, exRd = 0, memRd = 0, wbRd = 0;
  logic exMemRead = 0, memRegWrite = 0, wbRegWrite = 0;
  logic [XLEN-1:0] exRegVal1 = 32'h1111_1111, exRegVal2 = 32'h2222_2222;
  logic [XLEN-1:0] memResult = 32'hAAAA_0001, wbValue = 32'h5555_0002;
  logic [XLEN-1:0] idReadData1, idReadData2, opA, opB;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcHold, ifIdHold, bubble;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  bypass_unit #(.XLEN(XLEN), .NREGS(NREGS)) u_bypass_unit (.*);

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(input int src, input int mrd, input int mwe,
                                        input int wrd, input int wwe);
    if (mwe != 0 && mrd != 0 && mrd == src) return 2'b10;
    if (wwe != 0 && wrd != 0 && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] expOp(input logic [1:0] s, input logic [XLEN-1:0] rv);
    return (s == 2'b10) ? memResult : (s == 2'b01) ? wbValue : rv;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [1:0] es;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R10: reset clears every register
    for (int i = 0; i < NREGS; i++) begin
      idRs1 = i[IDX_W-1:0]; #0.2;
      check("R10 reset", idReadData1, 0);
    end
    // R8: write each register, read back next cycle
    for (int i = 0; i < NREGS; i++) begin
      @(negedge clk);
      wbRegWrite = 1; wbRd = i[IDX_W-1:0]; wbValue = 32'h100 + i * 17;
    end
    @(negedge clk); wbRegWrite = 0; #1;
    for (int i = 0; i < NREGS; i++) begin
      idRs1 = i[IDX_W-1:0]; idRs2 = i[IDX_W-1:0]; #0.2;
      check(i == 0 ? "R10 x0 write ignored" : "R8 stored", idReadData1,
            i == 0 ? 0 : 32'h100 + i * 17);
      check("R8 port2", idReadData2, i == 0 ? 0 : 32'h100 + i * 17);
    end
    // R8: disabled write changes nothing
    @(negedge clk); wbRegWrite = 0; wbRd = 3; wbValue = 32'hDEAD_BEEF;
    @(negedge clk); idRs1 = 3; #0.2;
    check("R8 no write when disabled", idReadData1, 32'h100 + 3 * 17);
    // R9: write-first same cycle
    wbRegWrite = 1; wbRd = 5; wbValue = 32'hCAFE_0005; idRs2 = 5; idRs1 = 4; #0.2;
    check("R9 write-first", idReadData2, 32'hCAFE_0005);
    check("R9 other port", idReadData1, 32'h100 + 4 * 17);
    wbRd = 0; idRs2 = 0; #0.2;
    check("R10 x0 write-first", idReadData2, 0);
    @(negedge clk); wbRegWrite = 0;
    wbValue = 32'h5555_0002;

    // R1 R2 R3 R5: operand A sweep, operand B held on index 0 (R4)
    exRs2 = 0;
    for (int s = 0; s < NREGS; s++)
      for (int m = 0; m < NREGS; m++)
        for (int w = 0; w < NREGS; w++)
          for (int e = 0; e < 4; e++) begin
            exRs1 = s[IDX_W-1:0]; memRd = m[IDX_W-1:0]; wbRd = w[IDX_W-1:0];
            memRegWrite = e[0]; wbRegWrite = e[1];
            #0.2;
            es = expSel(s, m, e[0], w, e[1]);
            check("R1/R2/R3 selA", fwdSelA, es);
            check("R5 opA", opA, expOp(es, exRegVal1));
            check("R4 selB independent", fwdSelB, 2'b00);
          end
    // operand B sweep with operand A pinned
    exRs1 = 7;
    for (int s = 0; s < NREGS; s++)
      for (int m = 0; m < NREGS; m++)
        for (int w = 0; w < NREGS; w++)
          for (int e = 0; e < 4; e++) begin
            exRs2 = s[IDX_W-1:0]; memRd = m[IDX_W-1:0]; wbRd = w[IDX_W-1:0];
            memRegWrite = e[0]; wbRegWrite = e[1];
            #0.2;
            es = expSel(s, m, e[0], w, e[1]);
            check("R1/R2/R3 selB", fwdSelB, es);
            check("R5 opB", opB, expOp(es, exRegVal2));
            check("R4 selA independent", fwdSelA, expSel(7, m, e[0], w, e[1]));
          end
    memRegWrite = 0; wbRegWrite = 0;

    // R6 R7: load-use sweep
    for (int d = 0; d < NREGS; d++)
      for (int a = 0; a < NREGS; a++)
        for (int b = 0; b < NREGS; b++)
          for (int l = 0; l < 2; l++) begin
            logic expH;
            exRd = d[IDX_W-1:0]; idRs1 = a[IDX_W-1:0]; idRs2 = b[IDX_W-1:0];
            exMemRead = l[0];
            #0.2;
            expH = (l == 1) && (d != 0) && (d == a || d == b);
            check(d == 0 ? "R7 zero dest no stall" : "R6 pcHold", pcHold, expH);
            check("R6 ifIdHold", ifIdHold, expH);
            check("R6 bubble", bubble, expH);
          end
    exMemRead = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule